// File: doc/BRIEF.md
# Key-Armed Watchdog with Timed Reset Output

This block is a watchdog for a small processor core. After a hardware reset it sits idle with its counter stopped. Software turns it on by writing a two-byte key to a single write-only register. The key is 0x1E immediately followed by 0xE1. Once the watchdog is on, the same key clears its counter.

While armed, the counter advances once per machine-cycle tick. If software fails to service it in time, the counter overflows. Overflow raises a one-clock system reset request and returns the watchdog to its disabled state. It can also drive the reset pin high for a fixed number of oscillator clocks.

Two configuration inputs adjust this behaviour. One suppresses the reset-pin drive. The other freezes counting while the core is in idle mode. Nothing in software can turn the watchdog off. The counter cannot be read.

Top module: `wdg_top`

## Requirements
- R1: After a synchronous reset (`rst` high), `sys_rst_req` and `rst_pin_drive` are 0. The watchdog is disabled, and without a valid key it never raises `sys_rst_req`, however many ticks arrive.
- R2: A write (`wr_en`=1) of 0x1E to address 0xA6, followed in the very next write to that address by 0xE1, arms the watchdog. Its counter starts from 0 at the clock edge of the 0xE1 write.
- R3: An armed watchdog raises `sys_rst_req` for exactly one clock after 2^CNT_W counted ticks since the last key (CNT_W defaults to 14, so 16384 ticks). The request is high in the clock after the edge that took the last tick.
- R4: While armed, the same 0x1E, 0xE1 key clears the counter. The next overflow then comes 2^CNT_W counted ticks after the edge of the 0xE1 write.
- R5: Writes to address 0xA6 other than 0x1E cancel a pending key. This includes 0xE1 when it does not directly follow 0x1E, and such writes neither arm nor clear the counter. A write of 0x1E always restarts the key. Writes to any other address have no effect.
- R6: No write disarms the watchdog. Only `rst` or an overflow returns it to disabled, and after an overflow no further request comes without a new key.
- R7: When `rto_disable` is 0 at the request, `rst_pin_drive` goes high one clock after `sys_rst_req` and stays high for exactly 98 clocks (PULSE_LEN). When `rto_disable` is 1, `rst_pin_drive` stays 0.
- R8: A tick is counted only when not (`idle`=1 and `idle_halt`=1). With `idle_halt` 0, ticks during idle are counted. With `idle_halt` 1, counting pauses during idle and resumes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Register write address |
| wr_data | input | 8 | Register write data |
| mc_tick | input | 1 | One-clock enable per machine cycle |
| idle | input | 1 | Core is in idle mode |
| rto_disable | input | 1 | 1 suppresses the reset-pin drive |
| idle_halt | input | 1 | 1 freezes counting during idle |
| sys_rst_req | output | 1 | One-clock system reset request on overflow |
| rst_pin_drive | output | 1 | Reset-pin high drive enable |

## Verification
The key takes effect at the clock edge of the 0xE1 write. The reset request appears one clock after the edge that took the final tick. The pin drive starts one clock after the request and lasts 98 clocks.

The bench samples at the falling edge, after the rising edge it is judging. Its model counts each tick present at that rising edge, skipping ticks that idle halts, and restarts the count on a key write. At the first request it compares that count with 2^CNT_W. It records the cycle numbers of the request and of the first drive, so both the one-clock delay and the drive length are checked exactly.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam logic [7:0] KEY_FIRST  = 8'h1E;
    localparam logic [7:0] KEY_SECOND = 8'hE1;

    typedef enum logic {
        KEY_WAIT = 1'b0,
        KEY_HALF = 1'b1
    } key_state_e;

    function automatic logic is_first(input logic [7:0] d);
        return d == KEY_FIRST;
    endfunction

    function automatic logic is_second(input logic [7:0] d);
        return d == KEY_SECOND;
    endfunction
endpackage

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA6
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              key_ok
);
    key_state_e state;
    logic       hit;

    always_comb begin
        hit    = wr_en && (wr_addr == REG_ADDR);
        key_ok = hit && (state == KEY_HALF) && is_second(wr_data);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state <= KEY_WAIT;
        end else if (hit) begin
            state <= is_first(wr_data) ? KEY_HALF : KEY_WAIT;
        end
    end

    // R5: a first-key write always leaves the sequence half done
    a_r5_first_restarts: assert property (@(posedge clk) disable iff (clr)
        hit && is_first(wr_data) |=> state == KEY_HALF);

    // R2: a completed key consumes the sequence
    a_r2_key_consumed: assert property (@(posedge clk) disable iff (clr)
        key_ok |=> state == KEY_WAIT);
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic key_ok,
    input  logic tick,
    input  logic hold,
    output logic ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             enabled;
    logic [CNT_W-1:0] count;
    logic             step;

    always_comb step = enabled && tick && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled <= 1'b0;
            count   <= '0;
            ovf     <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (key_ok) begin
                enabled <= 1'b1;
                count   <= '0;
            end else if (step) begin
                if (count == CNT_MAX) begin
                    ovf     <= 1'b1;
                    enabled <= 1'b0;
                    count   <= '0;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

    // R3: a counted tick below the top advances the counter by one
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        step && !key_ok && count != CNT_MAX |=> count == $past(count) + 1'b1);

    // R6: armed stays armed unless the final tick overflows
    a_r6_no_sw_disable: assert property (@(posedge clk) disable iff (rst)
        enabled && !(step && count == CNT_MAX) |=> enabled);

    // R1: a disabled watchdog holds its counter at zero and never requests
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !enabled && !key_ok |=> count == '0 && !ovf);
endmodule

// File: rtl/wdg_rstout.sv
module wdg_rstout #(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic inhibit,
    output logic drive
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (fire && !inhibit) begin
            remain <= PW'(PULSE_LEN);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    always_comb drive = (remain != '0);

    // R7: the pin drive only starts after an uninhibited request
    a_r7_drive_start: assert property (@(posedge clk) disable iff (rst)
        $rose(drive) |-> $past(fire) && !$past(inhibit));

    // R7: an inhibited request starts no drive
    a_r7_inhibited: assert property (@(posedge clk) disable iff (rst)
        fire && inhibit && !drive |=> !drive);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int PULSE_LEN = 98,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              mc_tick,
    input  logic              idle,
    input  logic              rto_disable,
    input  logic              idle_halt,
    output logic              sys_rst_req,
    output logic              rst_pin_drive
);
    logic key_ok;
    logic ovf;
    logic seq_clr;
    logic hold;

    always_comb begin
        seq_clr = rst || ovf;
        hold    = idle && idle_halt;
    end

    wdg_keyseq #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_key (
        .clk(clk), .clr(seq_clr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .key_ok(key_ok)
    );

    wdg_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .key_ok(key_ok), .tick(mc_tick),
        .hold(hold), .ovf(ovf)
    );

    wdg_rstout #(.PULSE_LEN(PULSE_LEN)) u_out (
        .clk(clk), .rst(rst), .fire(ovf), .inhibit(rto_disable),
        .drive(rst_pin_drive)
    );

    always_comb sys_rst_req = ovf;

    // R3: the reset request lasts a single clock
    a_r3_req_single: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req);
endmodule

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
    localparam int TB_W  = 8;
    localparam int FULL  = 1 << TB_W;
    localparam int PLEN  = 98;
    localparam int SPAN  = FULL * 12 + 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       mc_tick = 1'b0;
    logic       idle = 1'b0;
    logic       rto_disable = 1'b0;
    logic       idle_halt = 1'b0;
    logic       sys_rst_req;
    logic       rst_pin_drive;

    wdg_top #(.CNT_W(TB_W), .PULSE_LEN(PLEN)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mc_tick(mc_tick), .idle(idle),
        .rto_disable(rto_disable), .idle_halt(idle_halt),
        .sys_rst_req(sys_rst_req), .rst_pin_drive(rst_pin_drive)
    );

    always #5 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  div = 0;
    int  eff = 0;
    bit  key_flag = 0;
    int  req_n = 0, req_eff = 0, req_cyc = 0;
    int  drv_n = 0, drv_first = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: judge the edge just passed, then drive the next one
    task automatic step();
        @(negedge clk);
        cyc++;
        if (key_flag) eff = 0;
        else if (mc_tick && !(idle && idle_halt)) eff++;
        if (sys_rst_req) begin
            req_n++;
            if (req_n == 1) begin req_eff = eff; req_cyc = cyc; end
        end
        if (rst_pin_drive) begin
            drv_n++;
            if (drv_n == 1) drv_first = cyc;
        end
        div = (div == 11) ? 0 : div + 1;
        mc_tick = (div == 11);
        wr_en = 1'b0;
        key_flag = 0;
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit completes);
        wr_en = 1'b1; wr_addr = a; wr_data = d; key_flag = completes;
        step();
    endtask

    task automatic clear_obs();
        req_n = 0; drv_n = 0; eff = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        clear_obs();
    endtask

    task automatic arm();
        wr(8'hA6, 8'h1E, 0);
        wr(8'hA6, 8'hE1, 1);
    endtask

    task automatic wait_req();
        for (int i = 0; i < SPAN && req_n == 0; i++) step();
    endtask

    task automatic expect_ovf(input string tag);
        wait_req();
        check(req_n == 1, {tag, " request seen"}, req_n, 1);
        check(req_eff == FULL, {tag, " ticks to overflow"}, req_eff, FULL);
    endtask

    task automatic t_reset();
        do_reset();
        check(sys_rst_req == 0, "R1 reset req", sys_rst_req, 0);
        check(rst_pin_drive == 0, "R1 reset drive", rst_pin_drive, 0);
    endtask

    task automatic t_unarmed();
        do_reset();
        run(SPAN);
        check(req_n == 0, "R1 unarmed never requests", req_n, 0);
    endtask

    task automatic t_bad_seq();
        do_reset();
        wr(8'hA6, 8'h1E, 0);
        wr(8'hA6, 8'h55, 0);
        wr(8'hA6, 8'hE1, 0);
        wr(8'hA6, 8'hE1, 0);
        wr(8'h55, 8'h1E, 0);
        wr(8'hA6, 8'hE1, 0);
        wr(8'hA6, 8'h1E, 0);
        wr(8'h44, 8'hE1, 0);
        run(SPAN);
        check(req_n == 0, "R5 broken key does not arm", req_n, 0);
    endtask

    task automatic t_restart_and_pulse();
        do_reset();
        wr(8'hA6, 8'h1E, 0);
        wr(8'hA6, 8'h1E, 0);
        wr(8'hA6, 8'hE1, 1);
        expect_ovf("R2 R5 repeated first key arms, R3");
        run(PLEN + 20);
        check(drv_first == req_cyc + 1, "R7 drive one clock after request", drv_first - req_cyc, 1);
        check(drv_n == PLEN, "R7 drive length", drv_n, PLEN);
        run(SPAN);
        check(req_n == 1, "R6 disabled after overflow", req_n, 1);
    endtask

    task automatic t_service();
        do_reset();
        arm();
        run(150 * 12 + 5);
        check(req_n == 0, "R4 no request before service", req_n, 0);
        wr(8'hA6, 8'h1E, 0);
        wr(8'hA6, 8'hE1, 1);
        expect_ovf("R4 service restarts count");
    endtask

    task automatic t_no_disable();
        do_reset();
        arm();
        run(600);
        wr(8'hA6, 8'h00, 0);
        wr(8'hA6, 8'h1E, 0);
        wr(8'hA6, 8'h77, 0);
        wr(8'h12, 8'h00, 0);
        expect_ovf("R6 R5 stray writes neither disarm nor clear");
    endtask

    task automatic t_idle(input bit halt);
        do_reset();
        idle_halt = halt;
        arm();
        run(500);
        idle = 1'b1;
        run(1200);
        idle = 1'b0;
        expect_ovf(halt ? "R8 idle halts count" : "R8 idle keeps counting");
        idle_halt = 1'b0;
    endtask

    task automatic t_rto_off();
        do_reset();
        rto_disable = 1'b1;
        arm();
        expect_ovf("R3 overflow with drive off");
        run(PLEN + 20);
        check(drv_n == 0, "R7 drive suppressed", drv_n, 0);
        rto_disable = 1'b0;
    endtask

    task automatic t_hw_reset_mid();
        do_reset();
        arm();
        run(1000);
        do_reset();
        run(SPAN);
        check(req_n == 0, "R6 hardware reset disarms", req_n, 0);
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog timeout");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_unarmed();
        t_bad_seq();
        t_restart_and_pulse();
        t_service();
        t_no_disable();
        t_idle(1'b1);
        t_idle(1'b0);
        t_rto_off();
        t_hw_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule